// File: doc/BRIEF.md
# Quad DAC Channel Latch and Control Bank

This block sits behind a serial command receiver and keeps the digital state of four converter channels. Each accepted 16-bit command word names one channel and carries that channel's power-down bit, speed bit and 10-bit code. The word always lands in the channel's holding stage. It reaches the output stage at once only when simultaneous loading is enabled.

A level-sensitive, active-low load-enable input controls transfers from the holding stage to the output stage. While it is high, the outputs stay frozen and software can stage new values on several channels. When it goes low, all four output stages pick up their holding stages on the same clock edge. They keep tracking them for as long as the input stays low.

A separate active-low global power-down input forces every channel's effective power-down output. It leaves the stored codes and per-channel settings untouched, so they return unchanged when the input is released. Both asynchronous control inputs pass through two-flop synchronizers before use.

Top module: `qdac_latch_bank`

## Requirements
- R1: Word bits [15:14] select the channel (0 = channel 0 through 3 = channel 3). A word changes only the selected channel's state.
- R2: Word bit 13 is the channel power-down setting: 1 = powered down, 0 = active. It appears on `chanPd` of that channel.
- R3: Word bit 12 is the channel speed setting: 1 = fast settling, 0 = slow settling. It appears on `chanFast` of that channel.
- R4: Word bits [11:2] are the channel code and appear on that channel's slice of `chanCode`. Bits [1:0] have no effect on any output.
- R5: While the synchronized load-enable is low, the addressed channel's outputs show the new word in the cycle after `wordValid` is sampled.
- R6: While the synchronized load-enable is high, every output holds its value even when words are accepted.
- R7: After `loadEnN` falls, each output stage shows its holding stage three clock edges later (two synchronizer edges plus the latch edge), and not two edges later.
- R8: While the synchronized `gPdN` is low, every `chanPd` bit is 1. `chanCode` and `chanFast` are unchanged, and words still update the stored state.
- R9: After `gPdN` is released, each `chanPd` bit returns to that channel's stored power-down setting.
- R10: Reset clears all holding stages, output stages and settings to zero. The synchronizers reset to the inactive level (loading held off, no global power-down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordValid | input | 1 | One-cycle strobe marking a valid command word |
| wordData | input | 16 | Command word: address, power-down, speed, code |
| loadEnN | input | 1 | Asynchronous active-low simultaneous-load enable |
| gPdN | input | 1 | Asynchronous active-low global power-down |
| chanCode | output | 40 | Output-stage codes, channel n at bits [10n+9:10n] |
| chanPd | output | 4 | Effective power-down per channel |
| chanFast | output | 4 | Fast-settling select per channel |

## Verification
A word sampled on a clock edge is visible at the outputs one edge later when loading is open. A change on `loadEnN` takes three edges to reach the outputs, and a change on `gPdN` takes two edges to reach `chanPd`. The bench drives inputs on the falling edge and samples on the falling edge after the required number of rising edges. It waits a full synchronizer delay after each control change before it updates its model. In the load-enable case it also samples once, on purpose, at two edges, where the old value must still be present.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NUM_CH      = 4;
  localparam int CODE_W      = 10;
  localparam int WORD_W      = 16;
  localparam int SYNC_STAGES = 2;
  localparam int ADDR_W      = $clog2(NUM_CH);
  localparam int PD_BIT      = WORD_W - ADDR_W - 1;
  localparam int SPD_BIT     = PD_BIT - 1;
  localparam int CODE_MSB    = SPD_BIT - 1;

  typedef struct packed {
    logic              pd;
    logic              fast;
    logic [CODE_W-1:0] code;
  } chanCfg_t;

  typedef struct packed {
    logic [NUM_CH-1:0] holdWrEn;
    logic              copyAll;
    logic              forcePd;
  } strobes_t;

  function automatic chanCfg_t decodeWord(input logic [WORD_W-1:0] w);
    chanCfg_t c;
    c.pd   = w[PD_BIT];
    c.fast = w[SPD_BIT];
    c.code = w[CODE_MSB -: CODE_W];
    return c;
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= {STAGES{RST_VAL}};
    else       shReg <= {shReg[STAGES-2:0], d};
  end

  assign q = shReg[STAGES-1];
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              loadEnN,
  input  logic              gPdN,
  output strobes_t          strb
);
  logic loadSyncN;
  logic pdSyncN;

  qdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_loadSync (
    .clk(clk), .rstN(rstN), .d(loadEnN), .q(loadSyncN)
  );
  qdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pdSync (
    .clk(clk), .rstN(rstN), .d(gPdN), .q(pdSyncN)
  );

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      strb.holdWrEn[i] = wordValid && (wordAddr == ADDR_W'(i));
    end
    strb.copyAll = !loadSyncN;
    strb.forcePd = !pdSyncN;
  end

  AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.holdWrEn)); // R1
  AST_VALID_WRITES_ONE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> ($countones(strb.holdWrEn) == 1)); // R1
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> (strb.holdWrEn == '0)); // R6
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 strb,
  input  chanCfg_t                 newCfg,
  output logic [NUM_CH*CODE_W-1:0] chanCode,
  output logic [NUM_CH-1:0]        chanPd,
  output logic [NUM_CH-1:0]        chanFast
);
  chanCfg_t [NUM_CH-1:0] holdCfg;
  chanCfg_t [NUM_CH-1:0] outCfg;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdCfg[i] <= '0;
        outCfg[i]  <= '0;
      end else begin
        if (strb.holdWrEn[i]) holdCfg[i] <= newCfg;
        if (strb.copyAll)     outCfg[i]  <= strb.holdWrEn[i] ? newCfg : holdCfg[i];
      end
    end

    assign chanCode[i*CODE_W +: CODE_W] = outCfg[i].code;
    assign chanPd[i]   = outCfg[i].pd | strb.forcePd;
    assign chanFast[i] = outCfg[i].fast;

    AST_HOLD_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
      !strb.copyAll |=> $stable(outCfg[i])); // R6
    AST_OUT_TRACKS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      strb.copyAll |=> (outCfg[i] == holdCfg[i])); // R7
    AST_FORCED_CODE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      (strb.forcePd && !strb.copyAll) |=> $stable(chanCode[i*CODE_W +: CODE_W])); // R8
  end
endmodule

// File: rtl/qdac_latch_bank.sv
module qdac_latch_bank
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wordValid,
  input  logic [WORD_W-1:0]        wordData,
  input  logic                     loadEnN,
  input  logic                     gPdN,
  output logic [NUM_CH*CODE_W-1:0] chanCode,
  output logic [NUM_CH-1:0]        chanPd,
  output logic [NUM_CH-1:0]        chanFast
);
  strobes_t strb;
  chanCfg_t newCfg;

  assign newCfg = decodeWord(wordData);

  qdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid),
    .wordAddr(wordData[WORD_W-1 -: ADDR_W]),
    .loadEnN(loadEnN), .gPdN(gPdN), .strb(strb)
  );

  qdac_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .newCfg(newCfg),
    .chanCode(chanCode), .chanPd(chanPd), .chanFast(chanFast)
  );
endmodule

// File: tb/qdac_latch_bank_tb.sv
module qdac_latch_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 10;

  logic clk = 1'b0;
  logic rstN, wordValid, loadEnN, gPdN;
  logic [15:0] wordData;
  logic [NCH*CW-1:0] chanCode;
  logic [NCH-1:0] chanPd, chanFast;

  int checks = 0;
  int errors = 0;

  logic [11:0] expHold [NCH];
  logic [11:0] expOut  [NCH];
  logic        loadOpen;
  logic        pdForced;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_latch_bank u_dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .loadEnN(loadEnN), .gPdN(gPdN),
    .chanCode(chanCode), .chanPd(chanPd), .chanFast(chanFast)
  );

  // {pd, fast, code}: pd = bit 13, fast = bit 12, code = bits 11:2
  function automatic logic [11:0] wordCfg(input logic [15:0] w);
    return {w[13], w[12], w[11:2]};
  endfunction

  task automatic checkAll(input string req);
    for (int c = 0; c < NCH; c++) begin
      logic [11:0] got, exp;
      got = {chanPd[c], chanFast[c], chanCode[c*CW +: CW]};
      exp = {expOut[c][11] | pdForced, expOut[c][10:0]};
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s ch%0d: actual %h expected %h", req, c, got, exp);
      end
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w);
    wordValid = 1'b1;
    wordData  = w;
    @(negedge clk);
    wordValid = 1'b0;
    wordData  = $urandom;
    expHold[w[15:14]] = wordCfg(w);
    if (loadOpen) expOut[w[15:14]] = wordCfg(w);
  endtask

  task automatic setLoad(input logic open);
    loadEnN  = !open;
    cycles(3);
    loadOpen = open;
    if (open) for (int c = 0; c < NCH; c++) expOut[c] = expHold[c];
  endtask

  task automatic setPd(input logic force_);
    gPdN = !force_;
    cycles(3);
    pdForced = force_;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; wordValid = 1'b0; wordData = '0; loadEnN = 1'b1; gPdN = 1'b1;
    loadOpen = 1'b0; pdForced = 1'b0;
    for (int c = 0; c < NCH; c++) begin expHold[c] = '0; expOut[c] = '0; end
    cycles(4);
    rstN = 1'b1;
    cycles(1);
    checkAll("R10 reset clear");

    // R1 R2 R3 R4 R5: channel 2, pd=1 fast=1 code=3FF, don't-care bits set
    setLoad(1'b1);
    sendWord({2'b10, 1'b1, 1'b1, 10'h3FF, 2'b11});
    checkAll("R1 R2 R3 R4 R5 direct write");
    // R4: don't-care bits differ, same cfg on channel 0
    sendWord({2'b00, 1'b0, 1'b1, 10'h155, 2'b00});
    sendWord({2'b00, 1'b0, 1'b1, 10'h155, 2'b11});
    checkAll("R4 low bits ignored");

    // R6: lock outputs, stage all channels
    setLoad(1'b0);
    for (int c = 0; c < NCH; c++)
      sendWord({c[1:0], c[0], c[1], 10'(c * 100 + 7), 2'b01});
    checkAll("R6 outputs held");

    // R7: at two edges after fall still old, at three edges new
    loadEnN = 1'b0;
    cycles(2);
    checkAll("R7 not yet copied");
    cycles(1);
    loadOpen = 1'b1;
    for (int c = 0; c < NCH; c++) expOut[c] = expHold[c];
    checkAll("R7 simultaneous copy");

    // R8: global power-down forces pd, keeps codes
    setPd(1'b1);
    checkAll("R8 global power-down");
    sendWord({2'b01, 1'b0, 1'b0, 10'h2AA, 2'b00});
    checkAll("R8 write while forced");
    setPd(1'b0);
    checkAll("R9 release restores");

    // randomized mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = $urandom_range(0, 11);
      if (sel < 8) begin
        sendWord(16'($urandom));
        checkAll("R1 R5 R6 random word");
      end else if (sel < 10) begin
        setLoad(!loadOpen);
        checkAll("R7 random load toggle");
      end else begin
        setPd(!pdForced);
        checkAll("R8 R9 random pd toggle");
      end
      cycles($urandom_range(0, 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule